// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Wrap

This block is a target on a two-wire serial bus (I2C) that gives a host access to a 20-byte register window, at offsets 00h to 13h. The clock and data lines are synchronized and deglitched. START, repeated START and STOP are detected. The target answers two 7-bit device addresses, and each address selects its own register space. An internal pointer is kept between transactions. A host can write one byte, read from the current pointer, or set the pointer and then read a burst. During a burst the pointer advances after every byte, and it wraps from the last offset back to zero.

The register storage sits outside the block. It is reached through a plain port: the space select, the offset, a one-cycle write strobe with its data, and a read-data input. The read-data input must follow the offset combinationally. The block drives the data line only through an open-drain enable. A power-fail input takes the serial side off the bus and leaves the pointer unchanged.

Top module: `ctl_i2c_regslave`

## Requirements
- R1: Device address 1101111 (control space, `reg_sel`=0) and 1010111 (second space, `reg_sel`=1) are acknowledged. Any other address is not acknowledged, and the target stays silent until the next START.
- R2: A write is START, address with R/W=0, one offset byte, one data byte. All three bytes are acknowledged. Exactly one `reg_wr` pulse follows, with `reg_addr` equal to the offset and `reg_wdata` equal to the data. A further byte in the same transaction is not acknowledged and causes no write.
- R3: After reset, `sda_oe`=0, `reg_wr`=0 and the pointer is 00h, so a read with no offset phase returns register 00h.
- R4: A random read (write-phase address, offset byte, repeated START, the same address with R/W=1) returns the register at the offset, shifted MSB first.
- R5: The target sends bytes while the host acknowledges them (SDA low on the ninth clock). After a host not-acknowledge, the target releases SDA and drives nothing more until the next START.
- R6: The pointer advances by one for each transmitted byte and wraps from 13h to 00h.
- R7: In a random read, if the read-phase address selects a different space than the write-phase address, the read address is not acknowledged.
- R8: An offset byte above 13h is reduced modulo 20 (for example, 19h selects 05h and FFh selects 0Fh).
- R9: The pointer persists across transactions. A later read without an offset phase continues from where the previous transfer left it.
- R10: While `pwr_fail` is high, SDA is never driven and no write strobe is issued. The pointer is kept.
- R11: `sda_oe` changes only while SCL is low. A START seen in the middle of a byte abandons that byte and begins a new address phase.
- R12: `reg_sel` shows the space of the last acknowledged device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pwr_fail | input | 1 | High takes the serial interface off the bus (synchronous) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| reg_sel | output | 1 | Register space: 0 control, 1 second |
| reg_addr | output | 5 | Register offset (current pointer) |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_sel`/`reg_addr`, combinational |

## Verification
The assertions assume a host that follows the bus rules. SDA may change while SCL is high only to form a START or a STOP. Each SCL level lasts longer than the filter delay of about six clocks. `pwr_fail` is synchronous and changes only while the bus is idle. The bench's host model meets these conditions. Each SCL phase is split into quarters of ten clocks, SDA is changed only in the first quarter of a low phase, and `pwr_fail` is toggled only between transactions. On its side of the bus, the bench reads SDA as the wired-AND of its own drive and the inverse of `sda_oe`.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
    localparam logic [6:0] DEV_CTRL = 7'b1101111;
    localparam logic [6:0] DEV_ALT  = 7'b1010111;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_TXLD, ST_SKIP
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_DEV, PH_WORD, PH_DATA
    } eng_ph_e;
endpackage

// File: rtl/ctl_i2c_linefilt.sv
module ctl_i2c_linefilt #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          f;
        logic [CW-1:0] cnt;
    } lf_s;

    lf_s lf_d, lf_q;

    always_comb begin
        lf_d    = lf_q;
        lf_d.s1 = din;
        lf_d.s2 = lf_q.s1;
        if (lf_q.s2 == lf_q.f) begin
            lf_d.cnt = '0;
        end else if (lf_q.cnt == CW'(STABLE - 1)) begin
            lf_d.f   = lf_q.s2;
            lf_d.cnt = '0;
        end else begin
            lf_d.cnt = lf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf_q <= '{s1: 1'b1, s2: 1'b1, f: 1'b1, cnt: '0};
        else        lf_q <= lf_d;
    end

    assign dout = lf_q.f;

    logic f_w, s2_w;
    assign f_w  = lf_q.f;
    assign s2_w = lf_q.s2;

    // R11
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_w != $past(f_w)) |-> ($past(s2_w) == f_w));
endmodule

// File: rtl/ctl_i2c_cond.sv
module ctl_i2c_cond #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw, filt;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        ctl_i2c_linefilt #(.STABLE(STABLE)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    typedef struct packed {
        logic [NLINE-1:0] prev;
    } cd_s;

    cd_s cd_d, cd_q;

    always_comb begin
        cd_d      = cd_q;
        cd_d.prev = filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '{prev: '1};
        else        cd_q <= cd_d;
    end

    assign scl_f     = filt[0];
    assign sda_f     = filt[1];
    assign scl_rise  = filt[0] & ~cd_q.prev[0];
    assign scl_fall  = ~filt[0] & cd_q.prev[0];
    assign bus_start = filt[0] & cd_q.prev[0] & cd_q.prev[1] & ~filt[1];
    assign bus_stop  = filt[0] & cd_q.prev[0] & ~cd_q.prev[1] & filt[1];
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
    import ctl_i2c_pkg::*;
#(
    parameter int         NREG     = 20,
    parameter logic [6:0] DEV_A    = DEV_CTRL,
    parameter logic [6:0] DEV_B    = DEV_ALT,
    localparam int        PW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [7:0]    rdata,
    output logic          sda_oe,
    output logic          sel,
    output logic [PW-1:0] addr,
    output logic          wr,
    output logic [7:0]    wdata
);
    typedef struct packed {
        eng_st_e       st;
        eng_ph_e       ph;
        logic [3:0]    cnt;
        logic [7:0]    sr;
        logic [7:0]    wd;
        logic [PW-1:0] ptr;
        logic          sel;
        logic          rd;
        logic          dummy;
        logic          oe;
        logic          wr;
    } eng_s;

    eng_s e_d, e_q;

    logic          hit_a, hit_b, space_bad;
    logic [PW-1:0] ptr_inc, ptr_fold;

    assign hit_a     = (e_q.sr[7:1] == DEV_A);
    assign hit_b     = (e_q.sr[7:1] == DEV_B);
    assign space_bad = e_q.sr[0] & e_q.dummy & (hit_b != e_q.sel);
    assign ptr_inc   = (e_q.ptr == PW'(NREG - 1)) ? '0 : e_q.ptr + 1'b1;
    assign ptr_fold  = PW'({24'd0, e_q.sr} % NREG);

    always_comb begin
        e_d    = e_q;
        e_d.wr = 1'b0;
        if (pwr_fail) begin
            e_d.st    = ST_IDLE;
            e_d.oe    = 1'b0;
            e_d.dummy = 1'b0;
        end else if (bus_stop) begin
            e_d.st    = ST_IDLE;
            e_d.oe    = 1'b0;
            e_d.dummy = 1'b0;
        end else if (bus_start) begin
            e_d.st  = ST_RX;
            e_d.ph  = PH_DEV;
            e_d.cnt = '0;
            e_d.oe  = 1'b0;
        end else begin
            unique case (e_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        e_d.sr  = {e_q.sr[6:0], sda_f};
                        e_d.cnt = e_q.cnt + 1'b1;
                    end else if (scl_fall && e_q.cnt == 4'd8) begin
                        unique case (e_q.ph)
                            PH_DEV: begin
                                if (!(hit_a || hit_b) || space_bad) begin
                                    e_d.st = ST_SKIP;
                                end else begin
                                    e_d.sel = hit_b;
                                    e_d.rd  = e_q.sr[0];
                                    e_d.oe  = 1'b1;
                                    e_d.st  = ST_ACK;
                                end
                            end
                            PH_WORD: begin
                                e_d.ptr   = ptr_fold;
                                e_d.dummy = 1'b1;
                                e_d.oe    = 1'b1;
                                e_d.st    = ST_ACK;
                            end
                            default: begin
                                e_d.wr = 1'b1;
                                e_d.wd = e_q.sr;
                                e_d.oe = 1'b1;
                                e_d.st = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        e_d.oe  = 1'b0;
                        e_d.cnt = '0;
                        if (e_q.ph == PH_DEV && e_q.rd) begin
                            e_d.sr  = {rdata[6:0], 1'b0};
                            e_d.oe  = ~rdata[7];
                            e_d.cnt = 4'd1;
                            e_d.ptr = ptr_inc;
                            e_d.st  = ST_TX;
                        end else if (e_q.ph == PH_DEV) begin
                            e_d.ph = PH_WORD;
                            e_d.st = ST_RX;
                        end else if (e_q.ph == PH_WORD) begin
                            e_d.ph = PH_DATA;
                            e_d.st = ST_RX;
                        end else begin
                            e_d.st = ST_SKIP;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (e_q.cnt == 4'd8) begin
                            e_d.oe = 1'b0;
                            e_d.st = ST_MACK;
                        end else begin
                            e_d.oe  = ~e_q.sr[7];
                            e_d.sr  = {e_q.sr[6:0], 1'b0};
                            e_d.cnt = e_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) e_d.st = sda_f ? ST_SKIP : ST_TXLD;
                end
                ST_TXLD: begin
                    if (scl_fall) begin
                        e_d.sr  = {rdata[6:0], 1'b0};
                        e_d.oe  = ~rdata[7];
                        e_d.cnt = 4'd1;
                        e_d.ptr = ptr_inc;
                        e_d.st  = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ST_IDLE, ph: PH_DEV, cnt: '0, sr: '0, wd: '0,
                     ptr: '0, sel: 1'b0, rd: 1'b0, dummy: 1'b0, oe: 1'b0, wr: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe = e_q.oe;
    assign sel    = e_q.sel;
    assign addr   = e_q.ptr;
    assign wr     = e_q.wr;
    assign wdata  = e_q.wd;

    // R11
    oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !pwr_fail && !bus_start && !bus_stop) |-> $stable(sda_oe));
    // R10
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!sda_oe && !wr));
    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr < PW'(NREG));
    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr);
endmodule

// File: rtl/ctl_i2c_regslave.sv
module ctl_i2c_regslave
    import ctl_i2c_pkg::*;
#(
    parameter int         NREG   = 20,
    parameter int         STABLE = 3,
    parameter logic [6:0] DEV_A  = DEV_CTRL,
    parameter logic [6:0] DEV_B  = DEV_ALT,
    localparam int        PW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          reg_sel,
    output logic [PW-1:0] reg_addr,
    output logic          reg_wr,
    output logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_rdata
);
    logic scl_f, sda_f, scl_rise, scl_fall, bus_start, bus_stop;

    ctl_i2c_cond #(.STABLE(STABLE)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    ctl_i2c_engine #(.NREG(NREG), .DEV_A(DEV_A), .DEV_B(DEV_B)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .rdata    (reg_rdata),
        .sda_oe   (sda_oe),
        .sel      (reg_sel),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata)
    );
endmodule

// File: tb/test_ctl_i2c_regslave.sv
module test_ctl_i2c_regslave;
    localparam int NREG = 20;
    localparam int Q    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_sel, reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    ctl_i2c_regslave i_ctl_i2c_regslave (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_sel  (reg_sel),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Register storage seen by the block
    logic [7:0] mem     [2][NREG];
    logic [7:0] exp_mem [2][NREG];
    int         wr_cnt = 0;
    logic [4:0] wr_addr_seen;
    logic [7:0] wr_data_seen;
    logic       wr_sel_seen;

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mem[0][i]     = 8'hA0 + 8'(i);
            mem[1][i]     = 8'h50 + 8'(i);
            exp_mem[0][i] = 8'hA0 + 8'(i);
            exp_mem[1][i] = 8'h50 + 8'(i);
        end
    end

    assign reg_rdata = mem[reg_sel][reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_sel][reg_addr] <= reg_wdata;
            wr_cnt       <= wr_cnt + 1;
            wr_addr_seen <= reg_addr;
            wr_data_seen <= reg_wdata;
            wr_sel_seen  <= reg_sel;
        end
    end

    // SDA drive changes while SCL is high (R11)
    int   oe_hi_changes = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    always @(posedge clk) begin
        if (scl_m && scl_prev && (sda_oe != oe_prev)) oe_hi_changes <= oe_hi_changes + 1;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    int checks = 0;
    int errs   = 0;
    int exp_ptr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        b = sda_bus; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nack);
    endtask

    task automatic get_byte(input logic host_nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(host_nack);
    endtask

    task automatic rand_read(input logic [6:0] dev, input logic [7:0] word, input int n,
                             input string tag);
        logic       a;
        logic [7:0] v;
        logic       s;
        s = (dev == 7'b1010111);
        bus_start();
        put_byte({dev, 1'b0}, a); chk({tag, " dev-write ack"}, a, 0);
        put_byte(word, a);        chk({tag, " offset ack"}, a, 0);
        bus_start();
        put_byte({dev, 1'b1}, a); chk({tag, " dev-read ack"}, a, 0);
        exp_ptr = int'(word) % NREG;
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, v);
            chk({tag, " data"}, v, exp_mem[s][exp_ptr]);
            exp_ptr = (exp_ptr + 1) % NREG;
        end
        bus_stop();
    endtask

    task automatic cur_read(input logic [6:0] dev, input int n, input string tag);
        logic       a;
        logic [7:0] v;
        logic       s;
        s = (dev == 7'b1010111);
        bus_start();
        put_byte({dev, 1'b1}, a); chk({tag, " dev-read ack"}, a, 0);
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, v);
            chk({tag, " data"}, v, exp_mem[s][exp_ptr]);
            exp_ptr = (exp_ptr + 1) % NREG;
        end
        bus_stop();
    endtask

    // Stimulus table: device address, offset byte, burst length
    localparam logic [17:0] VECS [6] = '{
        {7'b1101111, 8'h00, 3'd2},
        {7'b1010111, 8'h05, 3'd3},
        {7'b1101111, 8'h12, 3'd4},
        {7'b1010111, 8'h13, 3'd2},
        {7'b1101111, 8'h19, 3'd2},
        {7'b1101111, 8'hFF, 3'd1}
    };

    task automatic finish_run();
        chk("R11 sda_oe steady while SCL high", oe_hi_changes, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] v;
        int         w0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: reset state and pointer at zero
        chk("R3 sda_oe after reset", sda_oe, 0);
        chk("R3 reg_wr after reset", reg_wr, 0);
        chk("R3 reg_addr after reset", reg_addr, 0);
        exp_ptr = 0;
        cur_read(7'b1101111, 1, "R3 current read from reset");

        // R4/R5/R6/R8/R1/R12: table of random reads
        foreach (VECS[k]) begin
            rand_read(VECS[k][17:11], VECS[k][10:3], int'(VECS[k][2:0]), "R4/R5/R6/R8 vector");
            chk("R12 space select", reg_sel, VECS[k][17:11] == 7'b1010111);
        end

        // R2: single-byte write
        w0 = wr_cnt;
        bus_start();
        put_byte({7'b1101111, 1'b0}, a); chk("R2 dev ack", a, 0);
        put_byte(8'h03, a);              chk("R2 offset ack", a, 0);
        put_byte(8'hC3, a);              chk("R2 data ack", a, 0);
        bus_stop();
        exp_mem[0][3] = 8'hC3;
        chk("R2 one strobe", wr_cnt - w0, 1);
        chk("R2 strobe offset", wr_addr_seen, 3);
        chk("R2 strobe data", wr_data_seen, 8'hC3);
        chk("R2 strobe space", wr_sel_seen, 0);
        rand_read(7'b1101111, 8'h03, 1, "R2 readback");

        // R2: byte past the data byte is refused
        w0 = wr_cnt;
        bus_start();
        put_byte({7'b1010111, 1'b0}, a); chk("R2 dev ack", a, 0);
        put_byte(8'h04, a);              chk("R2 offset ack", a, 0);
        put_byte(8'h11, a);              chk("R2 data ack", a, 0);
        put_byte(8'h22, a);              chk("R2 extra byte nack", a, 1);
        bus_stop();
        exp_mem[1][4] = 8'h11;
        chk("R2 extra byte no strobe", wr_cnt - w0, 1);
        exp_ptr = 4;

        // R9: pointer continues across transactions
        cur_read(7'b1010111, 2, "R9 continue");
        chk("R12 second space selected", reg_sel, 1);

        // R1: unknown address refused and ignored
        bus_start();
        put_byte({7'b1010000, 1'b0}, a); chk("R1 bad address nack", a, 1);
        put_byte(8'h00, a);              chk("R1 ignored byte nack", a, 1);
        bus_stop();
        cur_read(7'b1101111, 1, "R1 pointer untouched");

        // R7: space mismatch in random read
        bus_start();
        put_byte({7'b1101111, 1'b0}, a); chk("R7 dev ack", a, 0);
        put_byte(8'h02, a);              chk("R7 offset ack", a, 0);
        bus_start();
        put_byte({7'b1010111, 1'b1}, a); chk("R7 mismatch nack", a, 1);
        bus_stop();
        exp_ptr = 2;
        cur_read(7'b1101111, 1, "R7 offset kept");

        // R5: after host nack the target stays silent
        bus_start();
        put_byte({7'b1101111, 1'b0}, a); chk("R5 dev ack", a, 0);
        put_byte(8'h00, a);              chk("R5 offset ack", a, 0);
        bus_start();
        put_byte({7'b1101111, 1'b1}, a); chk("R5 dev-read ack", a, 0);
        get_byte(1'b1, v);               chk("R5 first byte", v, exp_mem[0][0]);
        get_byte(1'b1, v);               chk("R5 released after nack", v, 8'hFF);
        bus_stop();
        chk("R5 sda_oe idle", sda_oe, 0);
        exp_ptr = 1;

        // R10: power fail
        pwr_fail = 1'b1;
        hq();
        w0 = wr_cnt;
        bus_start();
        put_byte({7'b1101111, 1'b0}, a); chk("R10 no ack", a, 1);
        put_byte(8'h07, a);              chk("R10 no ack offset", a, 1);
        put_byte(8'h99, a);              chk("R10 no ack data", a, 1);
        bus_stop();
        chk("R10 no strobe", wr_cnt - w0, 0);
        pwr_fail = 1'b0;
        hq();
        cur_read(7'b1101111, 1, "R10 pointer kept");

        // R11: START mid-byte restarts address phase
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        rand_read(7'b1101111, 8'h07, 1, "R11 resync");

        finish_run();
    end
endmodule